// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block sits beside a small processor core and decides which interrupt the core takes next. Every source is one of two kinds, fixed by a parameter. An event source latches its request into a pending flag. A level source has no flag and requests service only while its input is high. A source can win only when its own enable bit is set, the global enable is set, the core reports that it is ready, and no hold condition blocks entry. Among the sources that qualify, the lowest index wins. The block then issues a one-cycle take pulse with the vector index and the vector address.

The core sends back three pulses: return-from-interrupt, disable-all and instruction-retired. The global enable clears itself on entry and sets itself again on return. After each return, the interrupted code must retire one instruction before another interrupt can be taken. Software reaches the block through a small write port. That port writes the per-source enables, clears flags by writing ones, and writes the global enable. A select input moves the vector table from address zero to a boot-region base.

Top module: `irq_arbiter`

## Requirements
- R1: Source `i` has vector index `i+1`, because index 0 is reserved for reset. When several sources qualify in the same cycle, the source with the lowest index is taken.
- R2: Taking an interrupt clears the global enable on the same clock edge that raises `irq_take`. While `irq_take` is high, `gie_o` reads 0.
- R3: A `ret_exec` pulse without `cli_exec` sets `gie_o` to 1 on the next edge.
- R4: When an event source is taken, its flag clears on the same edge that raises `irq_take`. A write with `wr_addr`=1 clears every flag whose `wr_data` bit is 1 and leaves the other flags alone.
- R5: An event pulse that arrives while its enable or the global enable is off sets its flag, and the flag stays set. The source is taken in priority order once both enables are on.
- R6: Level sources never set a flag, so their `flag_o` bit is always 0. A level request that is gone before the source is enabled is never taken.
- R7: After `ret_exec`, the block takes no interrupt until one `instr_retire` pulse has arrived. The earliest take pulse is then two cycles after the cycle that carries `instr_retire`.
- R8: With `cli_exec` high in a cycle, no interrupt is taken in that cycle. The global enable is then 0 on the next edge, even if a global-enable write or `ret_exec` arrives in the same cycle.
- R9: `irq_vec` = base + index × `VEC_STEP`. The base is `BOOT_BASE` when `boot_sel` is 1 in the deciding cycle and 0 otherwise.
- R10: If an event and a write-one clear hit the same flag in the same cycle, the flag is set afterwards.
- R11: `irq_take` is a registered single-cycle pulse, and `irq_idx` and `irq_vec` are 0 while it is low. A take needs `core_rdy` high in the deciding cycle.
- R12: Write addresses: 0 loads the enables from `wr_data`, 1 clears flags by writing ones, 2 loads the global enable from `wr_data[0]`. Every state bit is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Request per source (event pulse or level) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 enables, 1 flag clear, 2 global enable |
| wr_data | input | N_SRC | Write data |
| core_rdy | input | 1 | Core can accept an interrupt this cycle |
| ret_exec | input | 1 | Return-from-interrupt executed |
| cli_exec | input | 1 | Disable-all instruction executed |
| instr_retire | input | 1 | One instruction retired |
| boot_sel | input | 1 | Place the vector table at the boot base |
| irq_take | output | 1 | Interrupt taken (one-cycle pulse) |
| irq_idx | output | IDX_W | Vector index of the taken source |
| irq_vec | output | ADDR_W | Vector address of the taken source |
| gie_o | output | 1 | Global enable state |
| flag_o | output | N_SRC | Pending flags (level bits read 0) |

## Verification
The bench builds the block with six sources, two of them level type (bits 2 and 5). It uses a vector spacing of 4 and a boot base of 0x1C00. These values bring both source kinds, the priority order across mixed kinds, and a non-zero, non-power-of-one spacing within reach. With few sources, random stimulus often makes several requests collide in one cycle. It also often lands a return, a disable-all and a write in the same cycle. Directed sequences cover the retire hold after a return, a disable-all that coincides with a global-enable write, and a clear that coincides with an event.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    WA_ENABLE = 2'd0,
    WA_CLEAR  = 2'd1,
    WA_GIE    = 2'd2,
    WA_NONE   = 2'd3
  } wr_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          N_SRC = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr_w1c,
  input  logic [N_SRC-1:0] take_clr,
  output logic [N_SRC-1:0] flags
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      assign flags[i] = 1'b0;
    end else begin : g_event
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst) f_q <= 1'b0;
        else     f_q <= (f_q & ~clr_w1c[i] & ~take_clr[i]) | evt[i];
      end
      assign flags[i] = f_q;

      AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> flags[i]); // R10
      AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (take_clr[i] && !evt[i]) |=> !flags[i]); // R4
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] onehot
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any    = 1'b1;
        idx    = IDX_W'(i + 1);
        onehot = N_SRC'(1) << i;
      end
    end
  end

  always_comb begin
    if (any) begin
      AST_PICK_LOWEST: assert ((req & (onehot - N_SRC'(1))) == '0 && (req & onehot) != '0); // R1
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic cli,
  input  logic ret,
  input  logic retire,
  input  logic take,
  input  logic wr_gie,
  input  logic wr_val,
  input  logic core_rdy,
  output logic gie,
  output logic allow
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie    <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (cli)         gie <= 1'b0;
      else if (take)   gie <= 1'b0;
      else if (ret)    gie <= 1'b1;
      else if (wr_gie) gie <= wr_val;

      if (ret)         hold_q <= 1'b1;
      else if (retire) hold_q <= 1'b0;
    end
  end

  assign allow = gie & ~cli & ~ret & ~hold_q & core_rdy;

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
    take |=> !gie); // R2
  AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
    (ret && !cli) |=> gie); // R3
  AST_CLI_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
    cli |=> !gie); // R8
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int               N_SRC      = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'b0000_0000,
  parameter int               ADDR_W     = 16,
  parameter int               VEC_STEP   = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  localparam int              IDX_W      = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [N_SRC-1:0]  wr_data,
  input  logic              core_rdy,
  input  logic              ret_exec,
  input  logic              cli_exec,
  input  logic              instr_retire,
  input  logic              boot_sel,
  output logic              irq_take,
  output logic [IDX_W-1:0]  irq_idx,
  output logic [ADDR_W-1:0] irq_vec,
  output logic              gie_o,
  output logic [N_SRC-1:0]  flag_o
);
  import irq_pkg::*;

  logic [N_SRC-1:0]  en_q;
  logic [N_SRC-1:0]  flags;
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  win_oh;
  logic [N_SRC-1:0]  take_clr;
  logic [N_SRC-1:0]  clr_w1c;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;
  logic              allow;
  logic              take_now;
  logic              gie;
  logic [ADDR_W-1:0] base;

  wr_addr_e wa;
  assign wa = wr_addr_e'(wr_addr);

  assign clr_w1c = (wr_en && wa == WA_CLEAR) ? wr_data : '0;

  irq_flag_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst(rst), .evt(src_req & ~LEVEL_MASK),
    .clr_w1c(clr_w1c), .take_clr(take_clr), .flags(flags)
  );

  assign pend = ((flags & ~LEVEL_MASK) | (src_req & LEVEL_MASK)) & en_q;

  irq_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req(pend), .any(win_any), .idx(win_idx), .onehot(win_oh)
  );

  irq_gate u_gate (
    .clk(clk), .rst(rst), .cli(cli_exec), .ret(ret_exec),
    .retire(instr_retire), .take(take_now),
    .wr_gie(wr_en && wa == WA_GIE), .wr_val(wr_data[0]),
    .core_rdy(core_rdy), .gie(gie), .allow(allow)
  );

  assign take_now = allow & win_any;
  assign take_clr = take_now ? (win_oh & ~LEVEL_MASK) : '0;
  assign base     = boot_sel ? BOOT_BASE : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      irq_take <= 1'b0;
      irq_idx  <= '0;
      irq_vec  <= '0;
    end else begin
      if (wr_en && wa == WA_ENABLE) en_q <= wr_data;
      irq_take <= take_now;
      irq_idx  <= take_now ? win_idx : '0;
      irq_vec  <= take_now ? (base + ADDR_W'(win_idx) * ADDR_W'(VEC_STEP)) : '0;
    end
  end

  assign gie_o  = gie;
  assign flag_o = flags;

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take); // R11
  AST_GIE_LOW_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !gie_o); // R2
  AST_CLI_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    cli_exec |=> !irq_take); // R8
  AST_RET_WAIT: assert property (@(posedge clk) disable iff (rst)
    ret_exec |=> !irq_take ##1 !irq_take); // R7
  AST_NO_RDY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !core_rdy |=> !irq_take); // R11
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam int N = 6;
  localparam logic [N-1:0] LVL = 6'b100100;
  localparam int AW = 16;
  localparam int STEP = 4;
  localparam logic [AW-1:0] BB = 16'h1C00;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_req = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd3;
  logic [N-1:0] wr_data = '0;
  logic core_rdy = 1'b1, ret_exec = 1'b0, cli_exec = 1'b0, instr_retire = 1'b0, boot_sel = 1'b0;
  logic irq_take, gie_o;
  logic [IW-1:0] irq_idx;
  logic [AW-1:0] irq_vec;
  logic [N-1:0] flag_o;

  always #2 clk = ~clk;

  irq_arbiter #(.N_SRC(N), .LEVEL_MASK(LVL), .ADDR_W(AW), .VEC_STEP(STEP), .BOOT_BASE(BB)) u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .core_rdy(core_rdy), .ret_exec(ret_exec), .cli_exec(cli_exec),
    .instr_retire(instr_retire), .boot_sel(boot_sel), .irq_take(irq_take),
    .irq_idx(irq_idx), .irq_vec(irq_vec), .gie_o(gie_o), .flag_o(flag_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // Reference model state
  logic [N-1:0] m_flag, m_en;
  logic m_gie, m_hold, m_take;
  logic [IW-1:0] m_idx;
  logic [AW-1:0] m_vec;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_flag = '0; m_en = '0; m_gie = 0; m_hold = 0; m_take = 0; m_idx = '0; m_vec = '0;
  endtask

  // One clock: compute model next state, advance, compare at negedge.
  task automatic step(input bit cmp);
    logic [N-1:0] pend, nf, ne;
    logic ok, tk, ng, nh;
    int w;
    pend = ((m_flag & ~LVL) | (src_req & LVL)) & m_en;
    ok = m_gie && !cli_exec && !ret_exec && !m_hold && core_rdy;
    w = lowest(pend);
    tk = ok && (w >= 0);
    nf = m_flag;
    if (wr_en && wr_addr == 2'd1) nf = nf & ~wr_data;
    if (tk) nf[w] = 1'b0;
    nf = (nf | src_req) & ~LVL;
    ng = cli_exec ? 1'b0 : tk ? 1'b0 : ret_exec ? 1'b1 : (wr_en && wr_addr == 2'd2) ? wr_data[0] : m_gie;
    nh = ret_exec ? 1'b1 : instr_retire ? 1'b0 : m_hold;
    ne = (wr_en && wr_addr == 2'd0) ? wr_data : m_en;
    @(posedge clk);
    m_flag = nf; m_gie = ng; m_hold = nh; m_en = ne; m_take = tk;
    m_idx = tk ? IW'(w + 1) : '0;
    m_vec = tk ? ((boot_sel ? BB : '0) + AW'(w + 1) * AW'(STEP)) : '0;
    @(negedge clk);
    cyc++;
    if (cmp) begin
      chk("R11 take", irq_take, m_take);
      chk("R1 idx", irq_idx, m_idx);
      chk("R9 vec", irq_vec, m_vec);
      chk("R2 gie", gie_o, m_gie);
      chk("R4 flags", flag_o, m_flag);
    end
  endtask

  task automatic idle();
    src_req = '0; wr_en = 0; wr_addr = 2'd3; wr_data = '0;
    ret_exec = 0; cli_exec = 0; instr_retire = 0; core_rdy = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      if (cyc > 100000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    model_reset();
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R12 reset state
    chk("R12 reset take", irq_take, 0);
    chk("R12 reset gie", gie_o, 0);
    chk("R12 reset flags", flag_o, 0);

    // R5 latched while disabled
    idle(); src_req = 6'b000010; step(0);
    idle(); step(0);
    chk("R5 latched flag", flag_o, 6'b000010);
    wr(2'd0, 6'b000010); step(0);
    idle(); wr(2'd2, 6'b000001); step(0);
    chk("R12 gie write", gie_o, 1);
    idle(); step(0);
    chk("R5 taken", irq_take, 1);
    chk("R1 idx src1", irq_idx, 2);
    chk("R9 vec base0", irq_vec, 8);
    chk("R4 hw clear", flag_o, 0);
    chk("R2 gie cleared", gie_o, 0);
    idle(); step(0);
    chk("R11 single pulse", irq_take, 0);

    // R1 priority, R3 ret, R7 retire hold, R9 boot base
    idle(); src_req = 6'b001001; step(0);
    idle(); wr(2'd0, 6'b001011); step(0);
    idle(); ret_exec = 1; step(0);
    chk("R3 ret sets gie", gie_o, 1);
    chk("R7 no take on ret", irq_take, 0);
    idle(); step(0);
    chk("R7 held w/o retire", irq_take, 0);
    idle(); instr_retire = 1; step(0);
    chk("R7 held at retire", irq_take, 0);
    idle(); boot_sel = 1; step(0);
    chk("R7 take after retire", irq_take, 1);
    chk("R1 lowest wins", irq_idx, 1);
    chk("R9 boot vec", irq_vec, 16'h1C04);
    chk("R1 other pending", flag_o, 6'b001000);
    boot_sel = 0;

    // R8 disable-all
    idle(); ret_exec = 1; step(0);
    idle(); instr_retire = 1; step(0);
    idle(); cli_exec = 1; step(0);
    chk("R8 cli no take", irq_take, 0);
    chk("R8 cli gie off", gie_o, 0);
    idle(); cli_exec = 1; wr(2'd2, 6'b000001); step(0);
    chk("R8 cli beats write", gie_o, 0);
    idle(); wr(2'd2, 6'b000001); step(0);
    idle(); step(0);
    chk("R1 src3 taken", irq_idx, 4);
    chk("R9 vec src3", irq_vec, 16);

    // R4 write-one clear, R10 event wins
    idle(); src_req = 6'b001000; step(0);
    idle(); wr(2'd1, 6'b001000); step(0);
    chk("R4 w1c", flag_o, 0);
    idle(); src_req = 6'b001000; step(0);
    idle(); wr(2'd1, 6'b001000); src_req = 6'b001000; step(0);
    chk("R10 event wins", flag_o, 6'b001000);
    idle(); wr(2'd1, 6'b111111); step(0);

    // R6 level sources
    idle(); wr(2'd0, 6'b000100); src_req = 6'b000100; step(0);
    idle(); src_req = 6'b100100; step(0);
    chk("R6 no level flag", flag_o, 0);
    idle(); wr(2'd2, 6'b000001); step(0);
    idle(); step(0);
    idle(); step(0);
    chk("R6 lost level", irq_take, 0);
    idle(); src_req = 6'b000100; step(0);
    chk("R6 level taken", irq_idx, 3);
    chk("R9 level vec", irq_vec, 12);

    // Random phase against the model
    idle(); rst = 1; @(posedge clk); @(negedge clk); rst = 0; model_reset();
    for (int k = 0; k < 4000; k++) begin
      src_req = N'($urandom & $urandom & $urandom);
      wr_en = ($urandom % 6) == 0;
      wr_addr = 2'($urandom);
      wr_data = N'($urandom);
      core_rdy = ($urandom % 4) != 0;
      ret_exec = ($urandom % 8) == 0;
      cli_exec = ($urandom % 16) == 0;
      instr_retire = ($urandom % 2) == 0;
      boot_sel = 1'($urandom);
      step(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule